// File: doc/BRIEF.md
# Board Control Register File

This block is a small memory-mapped register file that sits on a development board's local bus. It provides two read-only identification words and an eight-bit LED bar. It also holds the text for an eight-cell character display, a one-cycle system reset request guarded by a key value, and a general-purpose output byte. The remaining registers let software bit-bang an I2C bus that is wired to an EEPROM responder.

Software talks to it with single 32-bit accesses. A request is presented for one cycle with `reqValid`. A write takes effect at that clock edge. A read returns its data with `rspValid` one cycle later. The display text is exposed as a flat 64-bit vector, with cell 0 in bits [7:0], for the display driver outside the block.

Top module: `board_regs`

## Requirements
- R1: Only address bits [19:0] take part in decoding, so the bits above them have no effect. The map uses these offsets:
  - 0x000: switch word.
  - 0x008: status word.
  - 0x100: LED bar.
  - 0x410: hex word.
  - 0x418 + 8*i, for i = 0..7: display cell i.
  - 0x500: soft reset.
  - 0x600: general-purpose output.
  - 0x700: I2C input.
  - 0x708: I2C output enable.
  - 0x710: I2C output.
  - 0x718: I2C select.
- R2: After reset, the LED bar, the general-purpose byte, the output-enable and select bits, SCL, SDA and the bad-address flag are all 0, and every display cell holds a space (0x20).
- R3: The switch word reads 0, meaning all switches are closed. The status word reads the parameter `STATUS_VALUE`.
- R4: A write to the LED bar keeps bits [7:0] of the data. A read returns them zero-extended.
- R5: A write to the hex word turns the 32-bit value into eight uppercase ASCII hex digits. The most significant nibble goes to cell 0. The hex word itself reads 0.
- R6: A write to display cell i stores data bits [7:0] in that cell only. A read of that cell returns the character zero-extended.
- R7: Writing exactly 0x00000042 to the soft-reset offset raises `sysResetReq` for exactly one cycle, the cycle after the write edge. Any other value raises nothing.
- R8: The general-purpose register keeps 8 bits, the output-enable register keeps 2 bits and the select register keeps 1 bit. Each reads back zero-extended.
- R9: A write to the I2C output register drives `sclOut` from data bit 1 and `sdaOut` from data bit 0. A read returns {SCL, SDA} in bits [1:0].
- R10: The I2C input register reads bits [7:1] of `i2cExtIn` as latched one cycle earlier, with bit 0 replaced by the live `sdaIn`.
- R11: An access to any other offset, including a misaligned cell offset, reads 0 and changes no register. It also sets `badAddr`, which stays set until reset.
- R12: `rspValid` is high for exactly the cycle after each read request and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data |
| ledBar | output | 8 | LED bar state |
| dispText | output | 64 | Display cells, cell i at bits [8i+7:8i] |
| gpOut | output | 8 | General-purpose output byte |
| i2cOe | output | 2 | I2C output-enable bits |
| i2cSel | output | 1 | I2C select bit |
| sclOut | output | 1 | SCL driven to the EEPROM |
| sdaOut | output | 1 | SDA driven to the EEPROM |
| sdaIn | input | 1 | SDA driven by the EEPROM |
| i2cExtIn | input | 8 | Raw input bits that are latched for the I2C input register |
| sysResetReq | output | 1 | One-cycle system reset request |
| badAddr | output | 1 | Sticky unmapped-access flag |

## Verification
A wrong decode or a broken store shows up at the output ports at the negedge right after the write edge, because every register drives a port directly. A stale or shifted display cell is exposed by comparing all 64 bits of `dispText` after every write. A misrouted read mux shows up one cycle after the read, in `rspData`. A leaking soft-reset compare, or a pulse that lasts too long, shows on `sysResetReq` within two cycles.

// File: rtl/board_regs_pkg.sv
`timescale 1ns/1ps
package board_regs_pkg;
  localparam int DATA_W   = 32;
  localparam int DECODE_W = 20;
  localparam int CELLS    = DATA_W / 4;
  localparam int IDX_W    = $clog2(CELLS);

  localparam logic [DECODE_W-1:0] OFF_SWITCH = 20'h00000;
  localparam logic [DECODE_W-1:0] OFF_STATUS = 20'h00008;
  localparam logic [DECODE_W-1:0] OFF_LED    = 20'h00100;
  localparam logic [DECODE_W-1:0] OFF_WORD   = 20'h00410;
  localparam logic [DECODE_W-1:0] OFF_CHAR0  = 20'h00418;
  localparam logic [DECODE_W-1:0] OFF_CHARN  = OFF_CHAR0 + DECODE_W'((CELLS - 1) * 8);
  localparam logic [DECODE_W-1:0] OFF_SOFT   = 20'h00500;
  localparam logic [DECODE_W-1:0] OFF_GP     = 20'h00600;
  localparam logic [DECODE_W-1:0] OFF_I2CIN  = 20'h00700;
  localparam logic [DECODE_W-1:0] OFF_I2COE  = 20'h00708;
  localparam logic [DECODE_W-1:0] OFF_I2COUT = 20'h00710;
  localparam logic [DECODE_W-1:0] OFF_I2CSEL = 20'h00718;

  localparam logic [DATA_W-1:0] SOFT_KEY = 32'h0000_0042;
  localparam logic [7:0]        BLANK    = 8'h20;

  typedef enum logic [3:0] {
    RD_ZERO, RD_STATUS, RD_LED, RD_CHAR, RD_GP,
    RD_I2CIN, RD_OE, RD_I2COUT, RD_SEL
  } rdSel_e;

  typedef struct packed {
    logic             wrLed;
    logic             wrWord;
    logic             wrChar;
    logic [IDX_W-1:0] charIdx;
    logic             wrSoft;
    logic             wrGp;
    logic             wrOe;
    logic             wrI2cOut;
    logic             wrSel;
    logic             rdEn;
    rdSel_e           rdSel;
    logic             badHit;
  } strobe_t;

  function automatic logic [7:0] hexChar(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/board_regs_ctrl.sv
`timescale 1ns/1ps
module board_regs_ctrl
  import board_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqAddr,
  output strobe_t           stb
);
  logic [DECODE_W-1:0] off;
  logic [DECODE_W-1:0] charOff;
  logic                wr;
  logic                mapped;
  logic                charHit;

  assign off     = reqAddr[DECODE_W-1:0];
  assign charOff = off - OFF_CHAR0;
  assign wr      = reqValid & reqWrite;
  assign charHit = (off >= OFF_CHAR0) && (off <= OFF_CHARN) && (off[2:0] == 3'b000);

  always_comb begin
    stb         = '0;
    stb.rdSel   = RD_ZERO;
    stb.rdEn    = reqValid & ~reqWrite;
    stb.charIdx = charOff[IDX_W+2:3];
    mapped      = 1'b1;
    if (off == OFF_SWITCH) begin
      stb.rdSel = RD_ZERO;
    end else if (off == OFF_STATUS) begin
      stb.rdSel = RD_STATUS;
    end else if (off == OFF_LED) begin
      stb.rdSel = RD_LED;
      stb.wrLed = wr;
    end else if (off == OFF_WORD) begin
      stb.wrWord = wr;
    end else if (charHit) begin
      stb.rdSel  = RD_CHAR;
      stb.wrChar = wr;
    end else if (off == OFF_SOFT) begin
      stb.wrSoft = wr;
    end else if (off == OFF_GP) begin
      stb.rdSel = RD_GP;
      stb.wrGp  = wr;
    end else if (off == OFF_I2CIN) begin
      stb.rdSel = RD_I2CIN;
    end else if (off == OFF_I2COE) begin
      stb.rdSel = RD_OE;
      stb.wrOe  = wr;
    end else if (off == OFF_I2COUT) begin
      stb.rdSel    = RD_I2COUT;
      stb.wrI2cOut = wr;
    end else if (off == OFF_I2CSEL) begin
      stb.rdSel = RD_SEL;
      stb.wrSel = wr;
    end else begin
      mapped = 1'b0;
    end
    stb.badHit = reqValid & ~mapped;
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrLed, stb.wrWord, stb.wrChar, stb.wrSoft, stb.wrGp,
              stb.wrOe, stb.wrI2cOut, stb.wrSel, stb.badHit & reqWrite})) // R1
    else $error("write strobes overlap");
endmodule

// File: rtl/board_regs_dp.sv
`timescale 1ns/1ps
module board_regs_dp
  import board_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] STATUS_VALUE = 32'h0000_0002
)(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic                sdaIn,
  input  logic [7:0]          i2cExtIn,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic [7:0]          ledBar,
  output logic [CELLS*8-1:0]  dispText,
  output logic [7:0]          gpOut,
  output logic [1:0]          i2cOe,
  output logic                i2cSel,
  output logic                sclOut,
  output logic                sdaOut,
  output logic                sysResetReq,
  output logic                badAddr
);
  logic [7:0]        cellReg [CELLS];
  logic [7:0]        inLatch;
  logic [DATA_W-1:0] rdNext;

  generate
    for (genvar g = 0; g < CELLS; g++) begin : g_cell
      always_ff @(posedge clk) begin
        if (!rstN)
          cellReg[g] <= BLANK;
        else if (stb.wrWord)
          cellReg[g] <= hexChar(reqWdata[DATA_W-1-4*g -: 4]);
        else if (stb.wrChar && (stb.charIdx == IDX_W'(g)))
          cellReg[g] <= reqWdata[7:0];
      end
      assign dispText[8*g +: 8] = cellReg[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledBar      <= '0;
      gpOut       <= '0;
      i2cOe       <= '0;
      i2cSel      <= 1'b0;
      sclOut      <= 1'b0;
      sdaOut      <= 1'b0;
      sysResetReq <= 1'b0;
      badAddr     <= 1'b0;
      inLatch     <= '0;
    end else begin
      inLatch     <= i2cExtIn;
      sysResetReq <= stb.wrSoft && (reqWdata == SOFT_KEY);
      if (stb.badHit) badAddr <= 1'b1;
      if (stb.wrLed)  ledBar  <= reqWdata[7:0];
      if (stb.wrGp)   gpOut   <= reqWdata[7:0];
      if (stb.wrOe)   i2cOe   <= reqWdata[1:0];
      if (stb.wrSel)  i2cSel  <= reqWdata[0];
      if (stb.wrI2cOut) begin
        sclOut <= reqWdata[1];
        sdaOut <= reqWdata[0];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    case (stb.rdSel)
      RD_STATUS: rdNext = STATUS_VALUE;
      RD_LED:    rdNext = DATA_W'(ledBar);
      RD_CHAR:   rdNext = DATA_W'(cellReg[stb.charIdx]);
      RD_GP:     rdNext = DATA_W'(gpOut);
      RD_I2CIN:  rdNext = DATA_W'({inLatch[7:1], sdaIn});
      RD_OE:     rdNext = DATA_W'(i2cOe);
      RD_I2COUT: rdNext = DATA_W'({sclOut, sdaOut});
      RD_SEL:    rdNext = DATA_W'(i2cSel);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= stb.rdEn;
      rspData  <= stb.rdEn ? rdNext : '0;
    end
  end

  AST_SOFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> !sysResetReq) // R7
    else $error("reset request longer than one cycle");
  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrLed |=> $stable(ledBar)) // R4
    else $error("LED bar changed without a write");
  AST_I2C_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrI2cOut |=> (sclOut == $past(reqWdata[1])) && (sdaOut == $past(reqWdata[0]))) // R9
    else $error("I2C output not forwarded");
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    badAddr |=> badAddr) // R11
    else $error("bad-address flag cleared");
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(stb.rdEn)) // R12
    else $error("response without read");
endmodule

// File: rtl/board_regs.sv
`timescale 1ns/1ps
module board_regs
  import board_regs_pkg::*;
#(
  parameter logic [31:0] STATUS_VALUE = 32'h0000_0002
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic [7:0]  ledBar,
  output logic [63:0] dispText,
  output logic [7:0]  gpOut,
  output logic [1:0]  i2cOe,
  output logic        i2cSel,
  output logic        sclOut,
  output logic        sdaOut,
  input  logic        sdaIn,
  input  logic [7:0]  i2cExtIn,
  output logic        sysResetReq,
  output logic        badAddr
);
  strobe_t stb;

  board_regs_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .stb(stb)
  );

  board_regs_dp #(.STATUS_VALUE(STATUS_VALUE)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWdata(reqWdata),
    .sdaIn(sdaIn), .i2cExtIn(i2cExtIn),
    .rspValid(rspValid), .rspData(rspData), .ledBar(ledBar),
    .dispText(dispText), .gpOut(gpOut), .i2cOe(i2cOe), .i2cSel(i2cSel),
    .sclOut(sclOut), .sdaOut(sdaOut), .sysResetReq(sysResetReq),
    .badAddr(badAddr)
  );
endmodule

// File: tb/test_board_regs.sv
`timescale 1ns/1ps
module test_board_regs;
  localparam logic [31:0] STATUS = 32'h0000_0002;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic [7:0]  ledBar, gpOut;
  logic [63:0] dispText;
  logic [1:0]  i2cOe;
  logic        i2cSel, sclOut, sdaOut, sysResetReq, badAddr;
  logic        sdaIn = 1'b0;
  logic [7:0]  i2cExtIn = '0;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] mLed = 0, mGp = 0;
  logic [1:0] mOe = 0;
  logic       mSel = 0, mScl = 0, mSda = 0, mBad = 0;
  logic [7:0] mCell [8];

  board_regs #(.STATUS_VALUE(STATUS)) i_board_regs (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspData(rspData), .ledBar(ledBar), .dispText(dispText), .gpOut(gpOut),
    .i2cOe(i2cOe), .i2cSel(i2cSel), .sclOut(sclOut), .sdaOut(sdaOut),
    .sdaIn(sdaIn), .i2cExtIn(i2cExtIn), .sysResetReq(sysResetReq),
    .badAddr(badAddr)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] expHex(input logic [3:0] n);
    if (n < 10) return 8'd48 + 8'(n);
    return 8'd65 + 8'(n) - 8'd10;
  endfunction

  function automatic logic [63:0] expText();
    logic [63:0] t;
    for (int i = 0; i < 8; i++) t[8*i +: 8] = mCell[i];
    return t;
  endfunction

  function automatic logic [31:0] expRead(input logic [19:0] off);
    if (off == 20'h008) return STATUS;
    if (off == 20'h100) return {24'b0, mLed};
    if (off >= 20'h418 && off <= 20'h450 && off[2:0] == 0)
      return {24'b0, mCell[(off - 20'h418) >> 3]};
    if (off == 20'h600) return {24'b0, mGp};
    if (off == 20'h700) return {24'b0, i2cExtIn[7:1], sdaIn};
    if (off == 20'h708) return {30'b0, mOe};
    if (off == 20'h710) return {30'b0, mScl, mSda};
    if (off == 20'h718) return {31'b0, mSel};
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkPorts(input string req);
    check({req, "/R4 led"}, 64'(ledBar), 64'(mLed));
    check({req, "/R5 R6 text"}, dispText, expText());
    check({req, "/R8 gp"}, 64'({gpOut, i2cOe, i2cSel}), 64'({mGp, mOe, mSel}));
    check({req, "/R9 i2c"}, 64'({sclOut, sdaOut}), 64'({mScl, mSda}));
    check({req, "/R11 bad"}, 64'(badAddr), 64'(mBad));
  endtask

  task automatic doWrite(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic doRead(input logic [31:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
    d = rspData; v = rspValid;
  endtask

  task automatic readCheck(input string req, input logic [31:0] a);
    logic [31:0] d; logic v; logic [31:0] e;
    e = expRead(a[19:0]);
    doRead(a, d, v);
    check({req, "/R12 valid"}, 64'(v), 64'd1);
    check(req, 64'(d), 64'(e));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic v;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) mCell[i] = 8'h20;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R2 reset state
    checkPorts("R2 reset");
    check("R2 rst req", 64'(sysResetReq), 0);
    check("R12 idle valid", 64'(rspValid), 0);
    // R3 fixed words
    readCheck("R3 switch", 32'h1F00_0000);
    readCheck("R3 status", 32'h0000_0008);
    // R5 directed word
    doWrite(32'h0000_0410, 32'h0123_ABCF);
    for (int i = 0; i < 8; i++) mCell[i] = expHex(4'(32'h0123_ABCF >> (28 - 4*i)));
    check("R5 word text", dispText, 64'h4643_4241_3332_3130);
    readCheck("R5 word reads zero", 32'h0000_0410);
    // R7 soft reset
    doWrite(32'hABC0_0500, 32'h0000_0042);
    check("R7 pulse", 64'(sysResetReq), 1);
    @(negedge clk);
    check("R7 one cycle", 64'(sysResetReq), 0);
    doWrite(32'h0000_0500, 32'h0000_0142);
    check("R7 wrong key", 64'(sysResetReq), 0);
    // R10 input register
    i2cExtIn = 8'hA5; sdaIn = 0;
    repeat (2) @(negedge clk);
    readCheck("R10 in A5 sda0", 32'h0000_0700);
    check("R10 const", 64'(rspData), 64'h0A4);
    i2cExtIn = 8'h00; sdaIn = 1;
    repeat (2) @(negedge clk);
    readCheck("R10 in 00 sda1", 32'h0000_0700);
    // R11 unmapped
    doWrite(32'h0000_041C, 32'h0000_0055);
    mBad = 1;
    checkPorts("R11 misaligned write");
    readCheck("R11 unmapped read", 32'h0000_0300);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int op; logic [31:0] dat; logic [11:0] hi;
      op = $urandom % 9; dat = $urandom; hi = 12'($urandom);
      case (op)
        0: begin doWrite({hi, 20'h00100}, dat); mLed = dat[7:0]; end
        1: begin doWrite({hi, 20'h00410}, dat);
             for (int i = 0; i < 8; i++) mCell[i] = expHex(dat[31-4*i -: 4]); end
        2: begin int k; k = $urandom % 8;
             doWrite({hi, 20'h00418 + 20'(8*k)}, dat); mCell[k] = dat[7:0]; end
        3: begin doWrite({hi, 20'h00600}, dat); mGp = dat[7:0]; end
        4: begin doWrite({hi, 20'h00708}, dat); mOe = dat[1:0]; end
        5: begin doWrite({hi, 20'h00710}, dat); mScl = dat[1]; mSda = dat[0]; end
        6: begin doWrite({hi, 20'h00718}, dat); mSel = dat[0]; end
        7: begin doWrite({hi, 20'h00900 + 20'(dat[7:0])}, dat); mBad = 1; end
        default: begin
          logic [19:0] offs [12];
          offs = '{20'h0, 20'h8, 20'h100, 20'h410, 20'h418, 20'h450,
                   20'h600, 20'h700, 20'h708, 20'h710, 20'h718, 20'h804};
          i2cExtIn = 8'($urandom); sdaIn = 1'($urandom);
          repeat (2) @(negedge clk);
          readCheck("R1 R3 R6 R10 random read", {hi, offs[$urandom % 12]});
        end
      endcase
      check("R7 no stray pulse", 64'(sysResetReq), 0);
      checkPorts("R1 random");
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule